// File: doc/BRIEF.md
# Majority-Vote Cyclic Decoder with Syndrome Bypass

This block corrects a word read from memory that is protected by a one-step majority-vote decodable cyclic code: the difference-set code of length 21, which holds 11 data bits and corrects up to two bit errors. When a word is strobed in, an XOR network evaluates every parity check on it in the same cycle. If all checks are satisfied, the word is returned on the next cycle and no correction is attempted.

If any check fails, the word is loaded into a rotating register and corrected over 21 cycles. In each cycle the block forms five parity sums. Each sum includes the top register position, and no other position appears in more than one sum. If three or more sums are odd, the top bit is inverted. The register then rotates by one place, so every position takes its turn at the top. After 21 steps the word is back in its original alignment and is presented as the result.

The output is the whole corrected 21-bit codeword. A done strobe marks when it is valid, and a flag reports whether a fault was found.

Top module: `mlsd_decoder`

## Requirements
- R1: While reset is held and right after it, `done`, `busy` and `err_detected` are 0 and `data_out` is all zeros.
- R2: A word is clean when it has even overlap with every cyclic rotation of the 21-bit pattern with ones at positions {0,2,7,8,11}. A clean word accepted at a clock edge gives `done`=1, `data_out` equal to the input and `err_detected`=0 in the cycle after that edge, and `busy` stays 0.
- R3: A word that is not clean raises `busy` in the cycle after acceptance. `busy` stays high for exactly 21 cycles and falls in the same cycle that `done` pulses. `done` and `busy` are never high together.
- R4: A codeword with one flipped bit, at any position, is returned exactly as the original codeword.
- R5: A codeword with two flipped bits is returned exactly as the original codeword.
- R6: `err_detected` goes to 1 in the cycle after a faulty word is accepted, stays 1 through correction, and holds until the next accepted word. A clean word clears it.
- R7: `in_valid` is accepted only while `busy` is 0. A word presented during correction has no effect on the result or on the number of `done` pulses.
- R8: `done` is a one-cycle pulse. `data_out` changes only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word strobe, honoured only while idle |
| in_word | input | 21 | Received codeword |
| data_out | output | 21 | Corrected codeword, held between results |
| done | output | 1 | One-cycle pulse when `data_out` is updated |
| busy | output | 1 | Correction steps in progress |
| err_detected | output | 1 | Last accepted word failed a parity check |

## Verification
Two events can land on the same edge: the last correction step finishing (`busy` falling with `done`) and an arriving `in_valid`. Also, while correction runs, a new strobe can coincide with a rotation step. The bench provokes the second case by strobing a different clean word midway through a two-error decode. It then judges that the corrected output still equals the first word, that the latency is still 21 cycles and that exactly one `done` pulse appears. The checker watches for `done` with `busy`, and for a rising `done` while a decode is still in progress.

// File: rtl/mlsd_pkg.sv
package mlsd_pkg;
    parameter int unsigned CW_N  = 21;
    parameter int unsigned NCHK  = 5;
    parameter int unsigned DSET [NCHK] = '{0, 2, 7, 8, 11};

    localparam int unsigned CNT_W  = $clog2(CW_N);
    localparam int unsigned VOTE_W = $clog2(NCHK + 1);

    typedef logic [CW_N-1:0] cw_t;

    function automatic cw_t pattern_mask();
        cw_t m = '0;
        for (int i = 0; i < NCHK; i++) m[DSET[i]] = 1'b1;
        return m;
    endfunction

    function automatic cw_t rotl(cw_t v, int unsigned s);
        cw_t r;
        if (s == 0) r = v;
        else        r = (v << s) | (v >> (CW_N - s));
        return r;
    endfunction
endpackage

// File: rtl/mlsd_syndrome.sv
module mlsd_syndrome
    import mlsd_pkg::*;
(
    input  cw_t             word,
    output logic [CW_N-1:0] syn,
    output logic            nonzero
);
    for (genvar r = 0; r < CW_N; r++) begin : g_row
        localparam cw_t ROW = rotl(pattern_mask(), r);
        assign syn[r] = ^(word & ROW);
    end
    assign nonzero = |syn;
endmodule

// File: rtl/mlsd_voter.sv
module mlsd_voter
    import mlsd_pkg::*;
(
    input  cw_t  word,
    output logic flip
);
    logic [NCHK-1:0]   sums;
    logic [VOTE_W-1:0] tally;

    for (genvar i = 0; i < NCHK; i++) begin : g_sum
        localparam int unsigned SH = (CW_N - 1 - DSET[i]) % CW_N;
        localparam cw_t CHK = rotl(pattern_mask(), SH);
        assign sums[i] = ^(word & CHK);
    end

    always_comb begin
        tally = '0;
        for (int i = 0; i < NCHK; i++) tally = tally + {{(VOTE_W-1){1'b0}}, sums[i]};
    end

    assign flip = (tally > VOTE_W'(NCHK / 2));
endmodule

// File: rtl/mlsd_decoder.sv
module mlsd_decoder
    import mlsd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CW_N-1:0] in_word,
    output logic [CW_N-1:0] data_out,
    output logic            done,
    output logic            busy,
    output logic            err_detected
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        cw_t              work;
        cw_t              dout;
        logic             done;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    logic [CW_N-1:0] syn;
    logic            syn_nz;
    logic            flip;
    cw_t             fixed_w;
    cw_t             stepped_w;

    mlsd_syndrome u_syn (
        .word    (in_word),
        .syn     (syn),
        .nonzero (syn_nz)
    );

    mlsd_voter u_vote (
        .word (s_q.work),
        .flip (flip)
    );

    assign fixed_w   = s_q.work ^ {flip, {(CW_N-1){1'b0}}};
    assign stepped_w = {fixed_w[0], fixed_w[CW_N-1:1]};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (in_valid) begin
                if (!syn_nz) begin
                    s_d.dout = in_word;
                    s_d.done = 1'b1;
                    s_d.err  = 1'b0;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = '0;
                    s_d.work = in_word;
                    s_d.err  = 1'b1;
                end
            end
        end else begin
            s_d.work = stepped_w;
            s_d.cnt  = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_W'(CW_N - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.dout = stepped_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data_out     = s_q.dout;
    assign done         = s_q.done;
    assign busy         = s_q.busy;
    assign err_detected = s_q.err;
endmodule

// File: rtl/mlsd_decoder_chk.sv
module mlsd_decoder_chk
    import mlsd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [CW_N-1:0] data_out,
    input logic            done,
    input logic            busy,
    input logic            err_detected,
    input logic            syn_nz
);
    logic [CNT_W:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_CLEAN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && !syn_nz) |=> (done && !busy && !err_detected)); // R2
    AST_FAULT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && syn_nz) |=> (busy && !done)); // R3
    AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R3
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3
    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CNT_W+1)'(CW_N)); // R3
    AST_ERR_DURING: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> err_detected); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> done); // R8
    AST_DONE_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !in_valid) |=> !done); // R8
endmodule

bind mlsd_decoder mlsd_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .data_out     (data_out),
    .done         (done),
    .busy         (busy),
    .err_detected (err_detected),
    .syn_nz       (syn_nz)
);

// File: tb/mlsd_decoder_tb.sv
module mlsd_decoder_tb;
    localparam int N = 21;
    localparam logic [N-1:0] PAT = 21'h000985;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] in_word = '0;
    logic [N-1:0] data_out;
    logic         done, busy, err_detected;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] cws [4096];
    int ncw = 0;

    always #5 clk = ~clk;

    mlsd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .data_out(data_out), .done(done), .busy(busy), .err_detected(err_detected)
    );

    function automatic logic [N-1:0] rot(logic [N-1:0] v, int s);
        if (s == 0) return v;
        return (v << s) | (v >> (N - s));
    endfunction

    function automatic bit is_cw(logic [N-1:0] v);
        for (int r = 0; r < N; r++) if (^(v & rot(PAT, r))) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Feed a word; optionally strobe an intruder word while busy (R7).
    task automatic run_word(logic [N-1:0] orig, logic [N-1:0] rx, int nerr,
                            bit intrude, logic [N-1:0] other, string req);
        int k;
        bit busy_ok;
        logic [N-1:0] held;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = rx;
        @(negedge clk);
        in_valid = 1'b0;
        k = 0;
        busy_ok = 1'b1;
        while (!done && k < 60) begin
            if (!busy || !err_detected) busy_ok = 1'b0;
            if (intrude && k == 5) begin
                in_valid = 1'b1;
                in_word  = other;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        in_valid = 1'b0;
        check(done, {req, " done seen"}, N'(done), N'(1));
        check(k == (nerr == 0 ? 0 : 21), {req, " R3 latency"}, N'(k), N'(nerr == 0 ? 0 : 21));
        if (nerr != 0) check(busy_ok, {req, " R6 busy+err during decode"}, N'(busy_ok), N'(1));
        else           check(!busy, {req, " R2 busy low"}, N'(busy), N'(0));
        check(data_out == orig, req, data_out, orig);
        check(err_detected == (nerr != 0), {req, " R6 flag"}, N'(err_detected), N'(nerr != 0));
        held = data_out;
        @(negedge clk);
        check(!done, {req, " R8 single pulse"}, N'(done), N'(0));
        check(data_out == held, {req, " R8 hold"}, data_out, held);
    endtask

    function automatic logic [N-1:0] inject(logic [N-1:0] c, int nerr);
        int p1, p2;
        p1 = $urandom_range(N - 1);
        if (nerr >= 1) c[p1] = ~c[p1];
        if (nerr >= 2) begin
            p2 = $urandom_range(N - 1);
            while (p2 == p1) p2 = $urandom_range(N - 1);
            c[p2] = ~c[p2];
        end
        return c;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin : stim
        logic [N-1:0] c, o, e;
        int unused_seed;
        unused_seed = $urandom(32'h5eed1);
        for (int v = 0; v < (1 << N); v++)
            if (is_cw(N'(v)) && ncw < 4096) begin cws[ncw] = N'(v); ncw++; end
        check(ncw == 2048, "R2 code size", N'(ncw), N'(2048));

        repeat (3) @(negedge clk);
        check(!done && !busy && !err_detected && data_out == '0, "R1 reset state",
              {done, busy, err_detected}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy && !err_detected && data_out == '0, "R1 after release",
              data_out, '0);

        // directed: all-zero and a clean word
        run_word('0, '0, 0, 1'b0, '0, "R2 zero word");
        c = cws[ncw - 1];
        run_word(c, c, 0, 1'b0, '0, "R2 clean word");
        // directed: single error at each end, double error at both ends
        c = cws[ncw / 3];
        e = c; e[0] = ~e[0];
        run_word(c, e, 1, 1'b0, '0, "R4 err bit0");
        e = c; e[N-1] = ~e[N-1];
        run_word(c, e, 1, 1'b0, '0, "R4 err top bit");
        e = c; e[0] = ~e[0]; e[N-1] = ~e[N-1];
        run_word(c, e, 2, 1'b0, '0, "R5 err ends");
        // clean word after faulty clears flag
        run_word(cws[7], cws[7], 0, 1'b0, '0, "R6 flag clears");
        // intruder during busy
        c = cws[100];
        o = cws[200];
        run_word(c, inject(c, 2), 2, 1'b1, o, "R7 intrude ignored");

        // random mix
        for (int t = 0; t < 300; t++) begin
            int ne;
            ne = $urandom_range(2);
            c  = cws[$urandom_range(ncw - 1)];
            run_word(c, inject(c, ne), ne, 1'b0, '0,
                     ne == 0 ? "R2 random clean" : (ne == 1 ? "R4 random 1 err" : "R5 random 2 err"));
        end
        summary();
    end
endmodule